// File: doc/BRIEF.md
# Scanned Three-Decade Decimal Event Counter

This block counts events in decimal across three cascaded decades (units, tens, hundreds). Each falling edge of the event input advances the count by one unless the count mask is high. All decades update in the same system-clock cycle: a decade steps only when every lower decade sits at 9 and an event is taken. The top decade's carry raises a wrap flag so that further counters can be chained after this one.

Each decade has a four-bit holding register. While the freeze input is low, the register follows its decade. While freeze is high, the register keeps its value and the decades go on counting. The held digits share one four-bit bus, one digit at a time. Each falling edge of a slow scan input moves the bus to the next decade, and an active-low select line marks the decade being shown. A display can therefore show a steady reading while counting goes on.

The block runs from one system clock. The event and scan inputs are asynchronous. Each passes through a two-flop synchronizer, and its edge is found from the synchronized samples.

Top module: `bcd_scan_counter`

## Requirements
- R1: While `clear` is high and for as long as it stays high, `digit_bus` is 0, `wrap_flag` is 0 and `digit_sel_n` is 3'b110 (units selected).
- R2: The count advances by exactly one for each falling edge of `evt_in`. A rising edge alone leaves the count unchanged. The new count reaches the holding registers no later than 4 system clocks after the falling edge.
- R3: While `evt_mask` is high, falling edges of `evt_in` leave the count unchanged.
- R4: Each decade holds a BCD value from 0 to 9. A decade steps past 9 to 0 and carries one into the next decade in the same cycle, so 9 steps to 10 and 99 steps to 100.
- R5: The advance from 999 gives 000 and sets `wrap_flag` to 1. The flag stays at 1 until the next counted event, which clears it. No other advance sets it.
- R6: While `freeze` is high, the holding registers and the digits shown on `digit_bus` do not change, even if events are counted. After `freeze` returns low, the current count appears within one clock.
- R7: Each falling edge of `scan_in` moves the display to the next decade in the order units, tens, hundreds, units. Exactly one bit of `digit_sel_n` is low at any time: bit 0 is units, bit 1 is tens, bit 2 is hundreds. The selection stays put between scan edges.
- R8: `clear` sets the count, the holding registers and the scan position to zero. After release, counting starts again from 000 and the display starts at units.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clear | input | 1 | Master clear, active high, asynchronous assert |
| evt_in | input | 1 | Event input, counted on its falling edge |
| evt_mask | input | 1 | High blocks counting |
| freeze | input | 1 | High holds the displayed digits |
| scan_in | input | 1 | Slow scan input, each falling edge steps the display |
| digit_bus | output | 4 | BCD value of the selected held digit |
| digit_sel_n | output | 3 | Active-low, one-hot decade select |
| wrap_flag | output | 1 | High after a 999-to-000 roll-over, until the next counted event |

## Verification
If the carry chain is wrong inside, the cascade boundaries show it. A bad decade enable shows as a wrong digit right after the 9-to-10, 99-to-100 or 999-to-000 step, one scan pass later. A wrong scan ring shows on `digit_sel_n` at once, as more than one active select or as the wrong order within three scan steps. A hold register that leaks shows as a changed digit during the freeze window, before freeze is released.

// File: rtl/bcd_scan_pkg.sv
package bcd_scan_pkg;
   localparam int BCD_W = 4;
   typedef logic [BCD_W-1:0] bcd_t;
   localparam bcd_t BCD_TOP = 4'd9;
   localparam bcd_t BCD_ZERO = 4'd0;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
   parameter int STAGES  = 2,
   parameter bit FALLING = 1'b1
) (
   input  logic clk,
   input  logic clear,
   input  logic din,
   output logic pulse
);
   logic [STAGES-1:0] sync_q;
   logic              last_q;

   always_ff @(posedge clk or posedge clear) begin
      if (clear) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], din};
         last_q <= sync_q[STAGES-1];
      end
   end

   generate
      if (FALLING) begin : g_fall
         assign pulse = last_q & ~sync_q[STAGES-1];
      end else begin : g_rise
         assign pulse = ~last_q & sync_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/bcd_decade.sv
module bcd_decade
   import bcd_scan_pkg::*;
(
   input  logic clk,
   input  logic clear,
   input  logic step,
   output bcd_t digit,
   output logic carry
);
   bcd_t digit_q;

   always_ff @(posedge clk or posedge clear) begin
      if (clear) begin
         digit_q <= BCD_ZERO;
      end else if (step) begin
         digit_q <= (digit_q == BCD_TOP) ? BCD_ZERO : digit_q + 4'd1;
      end
   end

   assign digit = digit_q;
   assign carry = step && (digit_q == BCD_TOP);
endmodule

// File: rtl/scan_ring.sv
module scan_ring #(
   parameter int N = 3,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic             clk,
   input  logic             clear,
   input  logic             step,
   output logic [IDX_W-1:0] idx,
   output logic [N-1:0]     sel_n
);
   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk or posedge clear) begin
      if (clear) begin
         idx_q <= '0;
      end else if (step) begin
         idx_q <= (idx_q == IDX_W'(N-1)) ? '0 : idx_q + 1'b1;
      end
   end

   assign idx = idx_q;

   generate
      for (genvar i = 0; i < N; i++) begin : g_sel
         assign sel_n[i] = (idx_q != IDX_W'(i));
      end
   endgenerate
endmodule

// File: rtl/bcd_scan_counter.sv
module bcd_scan_counter
   import bcd_scan_pkg::*;
#(
   parameter int NUM_DIGITS  = 3,
   parameter int SYNC_STAGES = 2,
   localparam int IDX_W  = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1,
   localparam int FLAT_W = NUM_DIGITS * BCD_W
) (
   input  logic                  clk,
   input  logic                  clear,
   input  logic                  evt_in,
   input  logic                  evt_mask,
   input  logic                  freeze,
   input  logic                  scan_in,
   output logic [BCD_W-1:0]      digit_bus,
   output logic [NUM_DIGITS-1:0] digit_sel_n,
   output logic                  wrap_flag
);
   generate
      if (NUM_DIGITS < 1) begin : g_bad_digits
         $error("NUM_DIGITS must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic                  evt_fall;
   logic                  scan_step;
   logic                  take;
   logic [NUM_DIGITS:0]   chain;
   logic [FLAT_W-1:0]     count_flat;
   logic [FLAT_W-1:0]     held_flat;
   logic [IDX_W-1:0]      idx;
   logic                  wrap_q;

   edge_sync #(.STAGES(SYNC_STAGES), .FALLING(1'b1)) u_evt_sync (
      .clk(clk), .clear(clear), .din(evt_in), .pulse(evt_fall)
   );

   edge_sync #(.STAGES(SYNC_STAGES), .FALLING(1'b1)) u_scan_sync (
      .clk(clk), .clear(clear), .din(scan_in), .pulse(scan_step)
   );

   assign take     = evt_fall & ~evt_mask;
   assign chain[0] = take;

   generate
      for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_decade
         bcd_t digit_d;
         bcd_decade u_dec (
            .clk(clk), .clear(clear), .step(chain[d]),
            .digit(digit_d), .carry(chain[d+1])
         );
         assign count_flat[d*BCD_W +: BCD_W] = digit_d;

         always_ff @(posedge clk or posedge clear) begin
            if (clear) begin
               held_flat[d*BCD_W +: BCD_W] <= BCD_ZERO;
            end else if (!freeze) begin
               held_flat[d*BCD_W +: BCD_W] <= digit_d;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or posedge clear) begin
      if (clear) begin
         wrap_q <= 1'b0;
      end else if (take) begin
         wrap_q <= chain[NUM_DIGITS];
      end
   end

   scan_ring #(.N(NUM_DIGITS)) u_scan (
      .clk(clk), .clear(clear), .step(scan_step),
      .idx(idx), .sel_n(digit_sel_n)
   );

   always_comb begin
      digit_bus = BCD_ZERO;
      for (int i = 0; i < NUM_DIGITS; i++) begin
         if (idx == IDX_W'(i)) begin
            digit_bus = held_flat[i*BCD_W +: BCD_W];
         end
      end
   end

   assign wrap_flag = wrap_q;
endmodule

// File: rtl/bcd_scan_counter_chk.sv
module bcd_scan_counter_chk #(
   parameter int NUM_DIGITS = 3,
   localparam int FLAT_W = NUM_DIGITS * 4
) (
   input logic                  clk,
   input logic                  clear,
   input logic                  freeze,
   input logic                  scan_step,
   input logic [3:0]            digit_bus,
   input logic [NUM_DIGITS-1:0] digit_sel_n,
   input logic                  wrap_flag,
   input logic [FLAT_W-1:0]     held_flat,
   input logic [FLAT_W-1:0]     count_flat
);
   // R1 / R8: a sustained clear leaves the outputs at their idle values
   p_clear_idle_r1: assert property (@(posedge clk)
      (clear && $past(clear)) |-> (digit_bus == 4'd0 && !wrap_flag &&
                                   digit_sel_n == NUM_DIGITS'(~1)));

   // R7: exactly one active-low select
   p_sel_onehot_r7: assert property (@(posedge clk) disable iff (clear)
      $countones(~digit_sel_n) == 1);

   // R7: selection moves only on a scan step
   p_sel_hold_r7: assert property (@(posedge clk) disable iff (clear)
      !scan_step |=> $stable(digit_sel_n));

   // R4: the bus never carries a non-decimal code
   p_bcd_range_r4: assert property (@(posedge clk) disable iff (clear)
      digit_bus <= 4'd9);

   // R6: freeze keeps the holding registers
   p_freeze_hold_r6: assert property (@(posedge clk) disable iff (clear)
      freeze |=> $stable(held_flat));

   // R5: the wrap flag rises only with the count at zero
   p_wrap_zero_r5: assert property (@(posedge clk) disable iff (clear)
      $rose(wrap_flag) |-> count_flat == '0);
endmodule

bind bcd_scan_counter bcd_scan_counter_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
   .clk(clk), .clear(clear), .freeze(freeze), .scan_step(scan_step),
   .digit_bus(digit_bus), .digit_sel_n(digit_sel_n), .wrap_flag(wrap_flag),
   .held_flat(held_flat), .count_flat(count_flat)
);

// File: tb/bcd_scan_counter_tb.sv
module bcd_scan_counter_tb;
   logic       clk = 1'b0;
   logic       clear = 1'b1;
   logic       evt_in = 1'b0;
   logic       evt_mask = 1'b0;
   logic       freeze = 1'b0;
   logic       scan_in = 1'b0;
   logic [3:0] digit_bus;
   logic [2:0] digit_sel_n;
   logic       wrap_flag;

   int n_checks = 0;
   int n_fail   = 0;
   int eidx     = 0;

   always #2 clk = ~clk;

   bcd_scan_counter u_dut (
      .clk(clk), .clear(clear), .evt_in(evt_in), .evt_mask(evt_mask),
      .freeze(freeze), .scan_in(scan_in), .digit_bus(digit_bus),
      .digit_sel_n(digit_sel_n), .wrap_flag(wrap_flag)
   );

   // {pulses, mask, expected BCD count after the step}
   localparam logic [22:0] VEC [7] = '{
      {10'd5,  1'b0, 12'h005},
      {10'd3,  1'b1, 12'h005},
      {10'd5,  1'b0, 12'h010},
      {10'd89, 1'b0, 12'h099},
      {10'd1,  1'b0, 12'h100},
      {10'd3,  1'b1, 12'h100},
      {10'd23, 1'b0, 12'h123}
   };

   task automatic chk(input bit ok, input string tag,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_evt(input int n);
      for (int k = 0; k < n; k++) begin
         evt_in = 1'b1; cycles(4);
         evt_in = 1'b0; cycles(6);
      end
   endtask

   task automatic scan_once();
      scan_in = 1'b1; cycles(3);
      scan_in = 1'b0; cycles(6);
      eidx = (eidx + 1) % 3;
   endtask

   // reads all three held digits through one full scan pass (R7 order check)
   task automatic read_disp(output logic [11:0] v);
      v = '0;
      for (int k = 0; k < 3; k++) begin
         chk(digit_sel_n == ~(3'b001 << eidx), "R7 select", digit_sel_n, ~(3'b001 << eidx));
         v[eidx*4 +: 4] = digit_bus;
         scan_once();
      end
   endtask

   initial begin
      logic [11:0] v;
      cycles(3);
      // R1: idle values held during clear
      chk(digit_bus == 4'd0, "R1 bus", digit_bus, 0);
      chk(digit_sel_n == 3'b110, "R1 sel", digit_sel_n, 3'b110);
      chk(wrap_flag == 1'b0, "R1 wrap", wrap_flag, 0);
      clear = 1'b0;
      cycles(3);

      // table walk: R2 counting, R3 masking, R4 decade carry
      for (int i = 0; i < 7; i++) begin
         evt_mask = VEC[i][12];
         pulse_evt(int'(VEC[i][22:13]));
         evt_mask = 1'b0;
         read_disp(v);
         chk(v == VEC[i][11:0], VEC[i][12] ? "R3 masked" : "R2/R4 count", v, VEC[i][11:0]);
      end

      // R6: freeze keeps the display while counting continues
      freeze = 1'b1; cycles(1);
      pulse_evt(4);
      read_disp(v);
      chk(v == 12'h123, "R6 frozen", v, 12'h123);
      freeze = 1'b0; cycles(2);
      read_disp(v);
      chk(v == 12'h127, "R6 released", v, 12'h127);

      // R2: a rising edge alone does not count
      evt_in = 1'b1; cycles(10);
      read_disp(v);
      chk(v == 12'h127, "R2 rise only", v, 12'h127);
      evt_in = 1'b0; cycles(6);
      read_disp(v);
      chk(v == 12'h128, "R2 fall", v, 12'h128);

      // R8: clear in the middle of a scan position
      scan_once();
      clear = 1'b1; cycles(3);
      chk(digit_sel_n == 3'b110, "R8 sel", digit_sel_n, 3'b110);
      chk(digit_bus == 4'd0, "R8 bus", digit_bus, 0);
      clear = 1'b0; eidx = 0; cycles(3);
      read_disp(v);
      chk(v == 12'h000, "R8 count", v, 12'h000);

      // R5: roll-over from 999
      pulse_evt(999);
      read_disp(v);
      chk(v == 12'h999, "R4 max", v, 12'h999);
      chk(wrap_flag == 1'b0, "R5 no wrap", wrap_flag, 0);
      pulse_evt(1);
      chk(wrap_flag == 1'b1, "R5 wrap set", wrap_flag, 1);
      read_disp(v);
      chk(v == 12'h000, "R5 wrap count", v, 12'h000);
      chk(wrap_flag == 1'b1, "R5 wrap held", wrap_flag, 1);
      pulse_evt(1);
      chk(wrap_flag == 1'b0, "R5 wrap clear", wrap_flag, 0);
      read_disp(v);
      chk(v == 12'h001, "R5 after wrap", v, 12'h001);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule